// File: doc/BRIEF.md
# JTAG Debug Port Access Responder

This block sits behind a JTAG TAP controller on the target side and serves the debug-port scan registers. The TAP hands it the current 4-bit instruction and the Capture-DR, Shift-DR and Update-DR strobes. The block keeps the matching data register between TDI and TDO. For the two access instructions that register is 35 bits long: a 3-bit request field (read flag and two address bits) and a 32-bit data word. When Capture-DR occurs, the request field is replaced by a 3-bit acknowledge. When Update-DR occurs, the shifted request is carried out against a small debug-port register set or against an access-port register bus.

Reads are posted. A read request places its result in a posted-read buffer, and that buffer is loaded into the data field at the next Capture. Access-port requests go over an internal valid/ready request channel to a stub register bank. The stub stays busy for a parameterised number of TCK cycles per access, and it raises ready only when it is idle. The responder offers a request only when the acknowledge captured for that scan reported the stub as idle, so a request never waits on back-pressure. A scan that finds the stub busy is answered with WAIT and its request is dropped. Sticky overrun and error flags, an abort path and power-up handshake bits complete the debug-port side.

Top module: `dbgport_resp`

## Requirements
- R1: The instruction selects the data register. 0x8 selects the abort register, 0xA selects debug-port access, 0xB selects access-port access and 0xE selects the identification register. Any other value selects a 1-bit bypass register that captures 0. Every register shifts toward TDO, least significant bit first.
- R2: Under instruction 0xE, Capture loads a 32-bit identification value taken from a parameter with bit 0 forced to 1. Updates under this instruction have no effect.
- R3: The access register is 35 bits. Bit 0 is the read flag (1 = read), bits 2:1 are address bits A[3:2], and bits 34:3 are the data. On Capture, bits 2:0 load 3'b010 (OK) when the access port is idle and 3'b001 (WAIT) when it is busy. Bits 34:3 load the posted-read buffer.
- R4: A debug-port read posts its value, which comes back on the next Capture. The address values are: A=1 control/status, A=2 port select, A=0 reads zero. A=3 returns the posted buffer unchanged and has no other effect.
- R5: When a scan captured WAIT, its Update is discarded. A write has no effect and a read posts nothing.
- R6: When a request is discarded for WAIT and control bit 0 (overrun detect enable) is 1, sticky overrun (control bit 1) is set. When bit 0 is 0, the flag is left as it was.
- R7: An access-port request is addressed by port select bits 31:24 (port number), port select bits 7:4 (bank) and A[3:2]. Only port 0 with a bank below NUM_BANKS exists. A request to any other port or bank sets sticky error (control bit 5) and starts no access.
- R8: While control bit 1 or bit 5 is set, access-port requests are discarded. Debug-port requests still work.
- R9: Writing control/status updates bits 0, 28 and 30 from the write data. A 1 in bit 1 or bit 5 clears that flag. Bits 29 and 31 read back as bits 28 and 30 delayed by one cycle.
- R10: An access-port access keeps the port busy for AP_LAT TCK cycles after its Update. A Capture at least AP_LAT+1 cycles after that Update sees OK, and one cycle earlier sees WAIT. A read result lands in the posted buffer when the access completes.
- R11: An Update under instruction 0x8 with data value 1 cancels the pending access-port access, drops its result and makes the port idle. Any other value has no effect.
- R12: After reset, control/status, port select and the posted buffer are zero, and no access is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_sel | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | TAP in Capture-DR for this cycle |
| shift_dr | input | 1 | TAP in Shift-DR for this cycle |
| update_dr | input | 1 | TAP in Update-DR for this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |

## Verification
Nearly all internal state reaches TDO only through a later scan. A wrong posted buffer, port select or control value therefore shows up at the Capture of the scan that follows the read, and never earlier. A busy counter that is off by one shows as the wrong acknowledge at a Capture exactly AP_LAT cycles after an access. A sticky flag that fails to set or clear shows in two ways: in the control read-back, and because later access-port writes are lost or land when they should not. A failed abort shows as WAIT on the scan that follows it.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int DR_W = 35;
  localparam int DW   = 32;

  localparam logic [3:0] IR_ABORT  = 4'h8;
  localparam logic [3:0] IR_DPACC  = 4'hA;
  localparam logic [3:0] IR_APACC  = 4'hB;
  localparam logic [3:0] IR_IDCODE = 4'hE;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam logic [1:0] DPA_ZERO  = 2'd0;
  localparam logic [1:0] DPA_CTRL  = 2'd1;
  localparam logic [1:0] DPA_SEL   = 2'd2;
  localparam logic [1:0] DPA_RDBUF = 2'd3;

  localparam int CS_ORUNDET = 0;
  localparam int CS_ORUN    = 1;
  localparam int CS_ERR     = 5;
  localparam int CS_DBGREQ  = 28;
  localparam int CS_DBGACK  = 29;
  localparam int CS_SYSREQ  = 30;
  localparam int CS_SYSACK  = 31;

  typedef struct packed {
    logic          we;
    logic [5:0]    addr;
    logic [DW-1:0] wdata;
  } ap_req_t;
endpackage

// File: rtl/dbgp_dr_shift.sv
module dbgp_dr_shift
  import dbgp_pkg::*;
#(
  parameter logic [31:0] IDCODE = 32'h4A53_0E2C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ir,
  input  logic            capture,
  input  logic            shift,
  input  logic            tdi,
  input  logic [2:0]      cap_ack,
  input  logic [DW-1:0]   cap_data,
  output logic [DR_W-1:0] dr,
  output logic            tdo
);
  typedef enum logic [1:0] {K_BYP, K_ACC, K_ID} kind_e;
  kind_e kind;

  always_comb begin
    unique case (ir)
      IR_ABORT, IR_DPACC, IR_APACC: kind = K_ACC;
      IR_IDCODE:                    kind = K_ID;
      default:                      kind = K_BYP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr <= '0;
    end else if (capture) begin
      unique case (kind)
        K_ACC:   dr <= {cap_data, cap_ack};
        K_ID:    dr <= {3'b000, IDCODE[31:1], 1'b1};
        default: dr <= '0;
      endcase
    end else if (shift) begin
      unique case (kind)
        K_ACC:   dr <= {tdi, dr[DR_W-1:1]};
        K_ID:    dr <= {3'b000, tdi, dr[31:1]};
        default: dr <= {{(DR_W-1){1'b0}}, tdi};
      endcase
    end
  end

  assign tdo = dr[0];

  p_idcode_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && ir == IR_IDCODE) |=> dr[0]);

  p_ack_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (ir == IR_DPACC || ir == IR_APACC)) |=>
      (dr[2:0] == ACK_OK || dr[2:0] == ACK_WAIT));

  p_bypass_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && kind == K_BYP) |=> (dr == '0));
endmodule

// File: rtl/dbgp_ap_stub.sv
module dbgp_ap_stub
  import dbgp_pkg::*;
#(
  parameter int AP_LAT    = 40,
  parameter int NUM_BANKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  ap_req_t       req,
  input  logic          abort,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = NUM_BANKS * 4;
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = $clog2(AP_LAT + 1);

  logic [CW-1:0] cnt;
  ap_req_t       pend;
  logic          finish;
  logic [DW-1:0] mem [WORDS];

  assign req_ready = (cnt == '0);
  assign finish    = (cnt == CW'(1)) && !abort;
  assign done      = finish && !pend.we;
  assign rdata     = mem[pend.addr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else if (req_valid && req_ready) begin
      cnt  <= CW'(AP_LAT);
      pend <= req;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[w] <= '0;
      else if (finish && pend.we && pend.addr[AW-1:0] == AW'(w))
        mem[w] <= pend.wdata;
    end
  end

  p_offer_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);

  p_addr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req.addr >> AW) == '0));

  p_abort_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> req_ready);

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !abort) |=> !req_ready);
endmodule

// File: rtl/dbgp_dp_regs.sv
module dbgp_dp_regs
  import dbgp_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ir,
  input  logic            capture,
  input  logic            update,
  input  logic [DR_W-1:0] dr,
  input  logic            ap_ready,
  input  logic            ap_done,
  input  logic [DW-1:0]   ap_rdata,
  output logic            ap_valid,
  output ap_req_t         ap_req,
  output logic            ap_abort,
  output logic [2:0]      cap_ack,
  output logic [DW-1:0]   cap_data
);
  logic          wait_q;
  logic          orundet, orun, err;
  logic          dbg_req, sys_req, dbg_ack, sys_ack;
  logic [DW-1:0] sel_q, posted;
  logic [DW-1:0] ctrl_rd, dp_rd, wd;
  logic [1:0]    a;
  logic          rnw, acc_ir, upd_go, ap_try, ap_exists;
  logic [3:0]    bank;

  assign rnw    = dr[0];
  assign a      = dr[2:1];
  assign wd     = dr[DR_W-1:3];
  assign acc_ir = (ir == IR_DPACC) || (ir == IR_APACC);
  assign bank   = sel_q[7:4];

  assign ap_exists = (sel_q[31:24] == 8'd0) && (32'(bank) < NUM_BANKS);
  assign upd_go    = update && acc_ir && !wait_q;
  assign ap_try    = upd_go && (ir == IR_APACC) && !(orun || err);
  assign ap_valid  = ap_try && ap_exists;
  assign ap_abort  = update && (ir == IR_ABORT) && (wd == 32'd1);

  always_comb begin
    ap_req       = '0;
    ap_req.we    = !rnw;
    ap_req.addr  = {bank, a};
    ap_req.wdata = wd;
  end

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CS_ORUNDET] = orundet;
    ctrl_rd[CS_ORUN]    = orun;
    ctrl_rd[CS_ERR]     = err;
    ctrl_rd[CS_DBGREQ]  = dbg_req;
    ctrl_rd[CS_DBGACK]  = dbg_ack;
    ctrl_rd[CS_SYSREQ]  = sys_req;
    ctrl_rd[CS_SYSACK]  = sys_ack;
  end

  always_comb begin
    unique case (a)
      DPA_CTRL:  dp_rd = ctrl_rd;
      DPA_SEL:   dp_rd = sel_q;
      DPA_RDBUF: dp_rd = posted;
      default:   dp_rd = '0;
    endcase
  end

  assign cap_ack  = ap_ready ? ACK_OK : ACK_WAIT;
  assign cap_data = posted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      orundet <= 1'b0;
      orun    <= 1'b0;
      err     <= 1'b0;
      dbg_req <= 1'b0;
      sys_req <= 1'b0;
      dbg_ack <= 1'b0;
      sys_ack <= 1'b0;
      sel_q   <= '0;
      posted  <= '0;
    end else begin
      dbg_ack <= dbg_req;
      sys_ack <= sys_req;
      if (capture && acc_ir)
        wait_q <= !ap_ready;
      if (update && acc_ir && wait_q && orundet)
        orun <= 1'b1;
      if (ap_try && !ap_exists)
        err <= 1'b1;
      if (upd_go && ir == IR_DPACC) begin
        if (rnw) begin
          posted <= dp_rd;
        end else begin
          unique case (a)
            DPA_CTRL: begin
              orundet <= wd[CS_ORUNDET];
              dbg_req <= wd[CS_DBGREQ];
              sys_req <= wd[CS_SYSREQ];
              if (wd[CS_ORUN]) orun <= 1'b0;
              if (wd[CS_ERR])  err  <= 1'b0;
            end
            DPA_SEL: sel_q <= wd;
            default: ;
          endcase
        end
      end
      if (ap_done)
        posted <= ap_rdata;
    end
  end

  p_wait_keeps_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (update && acc_ir && wait_q) |=> $stable(sel_q));

  p_orun_on_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (update && acc_ir && wait_q && orundet) |=> orun);

  p_pwr_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ({sys_ack, dbg_ack} == $past({sys_req, dbg_req})));

  p_no_ap_when_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (orun || err) |-> !ap_valid);
endmodule

// File: rtl/dbgport_resp.sv
module dbgport_resp
  import dbgp_pkg::*;
#(
  parameter logic [31:0] IDCODE    = 32'h4A53_0E2C,
  parameter int          AP_LAT    = 40,
  parameter int          NUM_BANKS = 4
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic [3:0] ir_sel,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic       update_dr,
  input  logic       tdi,
  output logic       tdo
);
  logic [DR_W-1:0] dr;
  logic [2:0]      cap_ack;
  logic [DW-1:0]   cap_data;
  logic            ap_valid, ap_ready, ap_abort, ap_done;
  ap_req_t         ap_req;
  logic [DW-1:0]   ap_rdata;

  dbgp_dr_shift #(.IDCODE(IDCODE)) u_shift (
    .clk(tck), .rst_n(trst_n), .ir(ir_sel), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .cap_ack(cap_ack), .cap_data(cap_data),
    .dr(dr), .tdo(tdo)
  );

  dbgp_dp_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(tck), .rst_n(trst_n), .ir(ir_sel), .capture(capture_dr),
    .update(update_dr), .dr(dr), .ap_ready(ap_ready), .ap_done(ap_done),
    .ap_rdata(ap_rdata), .ap_valid(ap_valid), .ap_req(ap_req),
    .ap_abort(ap_abort), .cap_ack(cap_ack), .cap_data(cap_data)
  );

  dbgp_ap_stub #(.AP_LAT(AP_LAT), .NUM_BANKS(NUM_BANKS)) u_ap (
    .clk(tck), .rst_n(trst_n), .req_valid(ap_valid), .req_ready(ap_ready),
    .req(ap_req), .abort(ap_abort), .done(ap_done), .rdata(ap_rdata)
  );
endmodule

// File: tb/sim_dbgport_resp.sv
module sim_dbgport_resp;
  localparam int          LAT = 40;
  localparam logic [31:0] IDV = 32'h4A53_0E2C;
  localparam logic [3:0]  I_AB = 4'h8, I_DP = 4'hA, I_AP = 4'hB, I_ID = 4'hE;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic [3:0] ir_sel = 4'h0;
  logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic       tdo;
  int         n_run = 0, n_fail = 0;
  bit         done_flag = 1'b0;

  always #5 tck = ~tck;

  dbgport_resp #(.IDCODE(IDV), .AP_LAT(LAT), .NUM_BANKS(4)) u0 (
    .tck(tck), .trst_n(trst_n), .ir_sel(ir_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
  );

  function automatic logic [34:0] req(input logic rd, input logic [1:0] a, input logic [31:0] d);
    return {d, a, rd};
  endfunction

  task automatic check(input string rq, input logic [34:0] act, input logic [34:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic scan(input logic [3:0] ir, input int nb, input logic [34:0] din,
                      input int idle, output logic [34:0] dout);
    dout = '0;
    @(negedge tck);
    ir_sel = ir;
    capture_dr = 1'b1;
    @(posedge tck);
    for (int i = 0; i < nb; i++) begin
      @(negedge tck);
      capture_dr = 1'b0;
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1'b1;
      @(posedge tck);
    end
    @(negedge tck);
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(posedge tck);
    @(negedge tck);
    update_dr = 1'b0;
    repeat (idle) @(posedge tck);
  endtask

  task automatic dp_write(input logic [1:0] a, input logic [31:0] d);
    logic [34:0] r;
    scan(I_DP, 35, req(1'b0, a, d), 2, r);
  endtask

  task automatic dp_read(input logic [1:0] a, output logic [31:0] d);
    logic [34:0] r;
    scan(I_DP, 35, req(1'b1, a, '0), 2, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    d = r[34:3];
  endtask

  task automatic ap_read(input logic [1:0] a, output logic [2:0] ack, output logic [31:0] d);
    logic [34:0] r;
    scan(I_AP, 35, req(1'b1, a, '0), LAT, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    ack = r[2:0];
    d = r[34:3];
  endtask

  task automatic t_reset();
    logic [34:0] r;
    logic [31:0] d;
    scan(I_DP, 35, req(1'b1, 2'd1, '0), 2, r);
    check("R12 first capture ack OK, posted zero", r, {32'h0, 3'b010});
    scan(I_DP, 35, req(1'b1, 2'd2, '0), 2, r);
    check("R12 control/status zero", r, {32'h0, 3'b010});
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    check("R12 port select zero", r, {32'h0, 3'b010});
    dp_read(2'd3, d);
    check("R12 posted buffer zero", {3'b0, d}, 35'h0);
  endtask

  task automatic t_idcode_bypass();
    logic [34:0] r;
    scan(I_ID, 32, 35'h0, 2, r);
    check("R2 identification value bit0 forced", r, {3'b0, IDV[31:1], 1'b1});
    scan(I_ID, 32, 35'h0, 2, r);
    check("R2 identification stable after update", r, {3'b0, IDV[31:1], 1'b1});
    scan(4'h3, 2, 35'h1, 2, r);
    check("R1 bypass captures 0 then passes tdi", r, 35'h2);
  endtask

  task automatic t_dp_regs();
    logic [34:0] r;
    logic [31:0] d;
    dp_write(2'd2, 32'h0000_0010);
    scan(I_DP, 35, req(1'b1, 2'd2, '0), 2, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    check("R4 port select read posted", r, {32'h10, 3'b010});
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    check("R4 buffer read has no side effect", r, {32'h10, 3'b010});
    dp_read(2'd0, d);
    check("R4 address 0 reads zero", {3'b0, d}, 35'h0);
  endtask

  task automatic t_ap_access();
    logic [34:0] r;
    logic [2:0]  k;
    logic [31:0] d;
    scan(I_AP, 35, req(1'b0, 2'd1, 32'hCAFE_0001), LAT, r);
    ap_read(2'd1, k, d);
    check("R10 idle of AP_LAT gives OK", {32'h0, k}, {32'h0, 3'b010});
    check("R7 bank 1 word 1 read back", {3'b0, d}, {3'b0, 32'hCAFE_0001});
    scan(I_AP, 35, req(1'b1, 2'd1, '0), LAT - 1, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), LAT, r);
    check("R10 one cycle short gives WAIT", {32'h0, r[2:0]}, {32'h0, 3'b001});
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    check("R10 result landed in posted buffer", r, {32'hCAFE_0001, 3'b010});
    dp_write(2'd2, 32'h0000_0000);
    ap_read(2'd1, k, d);
    check("R7 bank 0 separate from bank 1", {3'b0, d}, 35'h0);
    dp_write(2'd2, 32'h0000_0010);
  endtask

  task automatic t_wait_overrun();
    logic [34:0] r;
    logic [2:0]  k;
    logic [31:0] d;
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h1111_2222), 0, r);
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h3333_4444), LAT, r);
    check("R5 busy port answers WAIT", {32'h0, r[2:0]}, {32'h0, 3'b001});
    ap_read(2'd1, k, d);
    check("R5 write under WAIT dropped", {3'b0, d}, {3'b0, 32'h1111_2222});
    dp_read(2'd1, d);
    check("R6 no overrun flag with detect off", {3'b0, d}, 35'h0);
    dp_write(2'd1, 32'h0000_0001);
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h1111_2222), 0, r);
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h3333_4444), LAT, r);
    dp_read(2'd1, d);
    check("R6 overrun flag set with detect on", {3'b0, d}, 35'h3);
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h5555_6666), LAT, r);
    dp_write(2'd1, 32'h0000_0003);
    dp_read(2'd1, d);
    check("R9 write one clears overrun", {3'b0, d}, 35'h1);
    ap_read(2'd1, k, d);
    check("R8 AP write while sticky discarded", {3'b0, d}, {3'b0, 32'h1111_2222});
  endtask

  task automatic t_error_power();
    logic [34:0] r;
    logic [31:0] d;
    dp_write(2'd2, 32'h0300_0010);
    scan(I_AP, 35, req(1'b1, 2'd1, '0), LAT, r);
    dp_read(2'd1, d);
    check("R7 missing port sets sticky error", {3'b0, d}, 35'h21);
    dp_write(2'd2, 32'h0000_0050);
    scan(I_AP, 35, req(1'b1, 2'd1, '0), LAT, r);
    dp_write(2'd1, 32'h0000_0021);
    dp_read(2'd1, d);
    check("R9 write one clears error", {3'b0, d}, 35'h1);
    dp_write(2'd2, 32'h0000_0010);
    dp_write(2'd1, 32'h5000_0001);
    dp_read(2'd1, d);
    check("R9 power acks mirror requests", {3'b0, d}, {3'b0, 32'hF000_0001});
  endtask

  task automatic t_abort();
    logic [34:0] r;
    logic [2:0]  k;
    logic [31:0] d;
    dp_write(2'd1, 32'h0000_0000);
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h7777_8888), 0, r);
    scan(I_AB, 35, req(1'b0, 2'd0, 32'h1), 0, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), 2, r);
    check("R11 abort makes port idle", {32'h0, r[2:0]}, {32'h0, 3'b010});
    ap_read(2'd1, k, d);
    check("R11 aborted write dropped", {3'b0, d}, {3'b0, 32'h1111_2222});
    scan(I_AP, 35, req(1'b0, 2'd1, 32'h9999_AAAA), 0, r);
    scan(I_AB, 35, req(1'b0, 2'd0, 32'h2), 0, r);
    scan(I_DP, 35, req(1'b1, 2'd3, '0), LAT, r);
    check("R11 abort value 2 ignored, still busy", {32'h0, r[2:0]}, {32'h0, 3'b001});
    ap_read(2'd1, k, d);
    check("R11 access completed after ignored abort", {3'b0, d}, {3'b0, 32'h9999_AAAA});
  endtask

  initial begin
    repeat (3) @(posedge tck);
    @(negedge tck);
    trst_n = 1'b1;
    t_reset();
    t_idcode_bypass();
    t_dp_regs();
    t_ap_access();
    t_wait_overrun();
    t_error_power();
    t_abort();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule